// File: doc/BRIEF.md
# Serial Port Core with Single-Word Data Handshake

This block is a memory-mapped asynchronous serial port. It has a three-word register window, one transmit shifter, one receive shifter and a one-byte receive holding register. One register word carries the outgoing byte, the "transmitter can accept" flag, the received byte and the "byte waiting" flag. Software polls that word to learn both directions' state.

To send, software checks that the transmit-ready flag reads 1. It then writes the byte with that same flag bit set. To receive, software checks that the receive-valid flag reads 1, takes the byte from the low eight bits, and writes the word back with the valid bit set to release the holding register. A control word stores the interface mode and two override bits, one for each flow-control direction, plus a sticky overrun flag. A rate word stores a step value and a scale value and presents them to an external bit-rate generator. That generator returns an oversampling strobe, `bit_tick`. Frames are 8N1, least significant bit first, and the line idles high.

Top module: `ser_port_core`

## Requirements
- R1: After reset the data word (offset 0x0) reads 0x200, the control word (offset 0x4) and the rate word (offset 0x8) read 0, `txd` is 1 and `rts_n` is 0.
- R2: The rate word stores the step in bits 15:0 and the scale in bits 27:16. Both fields read back from it and drive `rate_step` and `rate_scale`. Bits 31:28 read 0, and an unmapped offset (0xC) reads 0.
- R3: Bit 9 of the data word is the transmit-ready flag. A data write with bit 9 set while it reads 1 sends bits 7:0 as one frame on `txd`: a low start bit, eight data bits LSB first and a high stop bit, each OVS strobes long. Bit 9 reads 0 from that write until the stop bit has ended.
- R4: A data write with bit 9 clear starts no frame and leaves bit 9 reading 1.
- R5: A data write issued while bit 9 reads 0 is ignored; only the byte already accepted is sent. The control word keeps the interface mode in bits 3:2, the transmit override in bit 7 and the receive override in bit 8, and other written bits do not read back.
- R6: With the transmit override (control bit 7) clear, an accepted byte waits with `txd` high while `cts_n` is 1, and is sent once `cts_n` goes to 0. With the override set, `cts_n` is ignored.
- R7: A received frame with a high stop bit sets bit 8 of the data word and places the byte in bits 7:0. While bit 8 is 1 and the receive override is clear, `rts_n` is 1.
- R8: A data write with bit 8 set clears bit 8. `rts_n` then returns to 0.
- R9: A frame that completes while bit 8 is 1 is dropped: the held byte is unchanged and control bit 9 (overrun) is set. Overrun stays set until a control write with bit 9 set clears it.
- R10: With the receive override (control bit 8) set, `rts_n` stays 0 even while a byte is waiting.
- R11: A frame whose stop bit samples low is discarded: bit 8 stays 0, and the next good frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe, one cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| bit_tick | input | 1 | Oversampling strobe, OVS pulses per bit |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idles high |
| cts_n | input | 1 | Peer ready to accept (active low) |
| rts_n | output | 1 | Core ready to accept (active low) |
| if_mode | output | 2 | Stored interface mode (1 DTE, 2 DCE) |
| rate_step | output | 16 | Stored step value |
| rate_scale | output | 12 | Stored scale value |

## Verification
The assertions assume that `cts_n`, `bus_*` and `bit_tick` are synchronous to `clk`. They also assume `bit_tick` is a single-cycle pulse that never arrives on two consecutive cycles. The bench generates the strobe as one pulse every four clocks. It drives every bus and flow-control input on the falling clock edge. The receive line is the only asynchronous input, and it passes through a two-flop synchronizer. The bench drives each serial bit for exactly OVS strobe periods, so sampling at mid-bit sits well inside each bit.

// File: rtl/ser_pkg.sv
package ser_pkg;
    localparam int unsigned ADDR_W    = 4;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned DATA_BITS = 8;
    localparam int unsigned IDX_W     = $clog2(DATA_BITS);
    localparam int unsigned STEP_W    = 16;
    localparam int unsigned SCALE_W   = 12;

    localparam logic [ADDR_W-1:0] OFS_DATA = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_RATE = 4'h8;

    localparam int unsigned RXV_BIT   = 8;
    localparam int unsigned TXR_BIT   = 9;
    localparam int unsigned MODE_LSB  = 2;
    localparam int unsigned TXOVR_BIT = 7;
    localparam int unsigned RXOVR_BIT = 8;
    localparam int unsigned OVRN_BIT  = 9;
    localparam int unsigned SCALE_LSB = 16;

    typedef struct packed {
        logic       rx_ovr;
        logic       tx_ovr;
        logic [1:0] mode;
    } ctrl_t;

    typedef struct packed {
        logic [SCALE_W-1:0] scale;
        logic [STEP_W-1:0]  step;
    } rate_t;

    typedef enum logic [2:0] {TX_IDLE, TX_WAIT, TX_START, TX_DATA, TX_STOP} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

    function automatic logic [WORD_W-1:0] pack_ctrl(ctrl_t c, logic ovrn);
        logic [WORD_W-1:0] w;
        w = '0;
        w[MODE_LSB +: 2] = c.mode;
        w[TXOVR_BIT]     = c.tx_ovr;
        w[RXOVR_BIT]     = c.rx_ovr;
        w[OVRN_BIT]      = ovrn;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] pack_data(logic txr, logic rxv,
                                                    logic [DATA_BITS-1:0] b);
        logic [WORD_W-1:0] w;
        w = '0;
        w[DATA_BITS-1:0] = b;
        w[RXV_BIT]       = rxv;
        w[TXR_BIT]       = txr;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] pack_rate(rate_t r);
        logic [WORD_W-1:0] w;
        w = '0;
        w[STEP_W-1:0]                 = r.step;
        w[SCALE_LSB +: SCALE_W]       = r.scale;
        return w;
    endfunction
endpackage

// File: rtl/ser_tx.sv
module ser_tx
    import ser_pkg::*;
#(
    parameter int unsigned OVS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 load,
    input  logic [DATA_BITS-1:0] din,
    input  logic                 cts_ok,
    output logic                 ready,
    output logic                 txd
);
    localparam int unsigned CNT_W = $clog2(OVS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS - 1);

    tx_state_e            st;
    logic [CNT_W-1:0]     cnt;
    logic [IDX_W-1:0]     idx;
    logic [DATA_BITS-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= TX_IDLE;
            txd <= 1'b1;
            cnt <= '0;
            idx <= '0;
            sh  <= '0;
        end else begin
            case (st)
                TX_IDLE: if (load) begin
                    sh <= din;
                    st <= TX_WAIT;
                end
                TX_WAIT: if (tick && cts_ok) begin
                    st  <= TX_START;
                    txd <= 1'b0;
                    cnt <= '0;
                end
                default: if (tick) begin
                    if (cnt == CNT_LAST) begin
                        cnt <= '0;
                        case (st)
                            TX_START: begin
                                st  <= TX_DATA;
                                txd <= sh[0];
                                idx <= '0;
                            end
                            TX_DATA: begin
                                if (idx == IDX_LAST) begin
                                    st  <= TX_STOP;
                                    txd <= 1'b1;
                                end else begin
                                    txd <= sh[1];
                                    sh  <= sh >> 1;
                                    idx <= idx + 1'b1;
                                end
                            end
                            default: st <= TX_IDLE;
                        endcase
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign ready = (st == TX_IDLE);
endmodule

// File: rtl/ser_rx.sv
module ser_rx
    import ser_pkg::*;
#(
    parameter int unsigned OVS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 rxd,
    output logic                 done,
    output logic [DATA_BITS-1:0] dout
);
    localparam int unsigned CNT_W = $clog2(OVS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OVS / 2 - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS - 1);

    rx_state_e        st;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic [1:0]       sync;
    logic             rxs;

    assign rxs = sync[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync <= 2'b11;
            st   <= RX_IDLE;
            cnt  <= '0;
            idx  <= '0;
            dout <= '0;
            done <= 1'b0;
        end else begin
            sync <= {sync[0], rxd};
            done <= 1'b0;
            if (tick) begin
                case (st)
                    RX_IDLE: if (!rxs) begin
                        st  <= RX_START;
                        cnt <= '0;
                    end
                    RX_START: begin
                        if (cnt == CNT_HALF) begin
                            cnt <= '0;
                            idx <= '0;
                            st  <= rxs ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt == CNT_LAST) begin
                            cnt  <= '0;
                            dout <= {rxs, dout[DATA_BITS-1:1]};
                            if (idx == IDX_LAST) st <= RX_STOP;
                            else                 idx <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                        if (cnt == CNT_LAST) begin
                            cnt  <= '0;
                            done <= rxs;
                            st   <= RX_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/ser_regs.sv
module ser_regs
    import ser_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    input  logic                 tx_ready,
    output logic                 tx_load,
    output logic [DATA_BITS-1:0] tx_byte,
    input  logic                 rx_done,
    input  logic [DATA_BITS-1:0] rx_byte,
    output logic [DATA_BITS-1:0] rx_hold,
    output logic                 rx_full,
    output logic                 ovrn,
    output ctrl_t                ctrl,
    output rate_t                rate
);
    logic wr, wr_data, wr_ctrl, wr_rate, rx_ack;
    logic unused_hi;

    assign wr      = bus_valid && bus_write;
    assign wr_data = wr && (bus_addr == OFS_DATA);
    assign wr_ctrl = wr && (bus_addr == OFS_CTRL);
    assign wr_rate = wr && (bus_addr == OFS_RATE);
    assign rx_ack  = wr_data && bus_wdata[RXV_BIT];
    assign tx_load = wr_data && bus_wdata[TXR_BIT] && tx_ready;
    assign tx_byte = bus_wdata[DATA_BITS-1:0];
    assign unused_hi = ^bus_wdata[WORD_W-1:SCALE_LSB+SCALE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_hold <= '0;
            rx_full <= 1'b0;
            ovrn    <= 1'b0;
            ctrl    <= '0;
            rate    <= '0;
        end else begin
            if (rx_done && (!rx_full || rx_ack)) begin
                rx_hold <= rx_byte;
                rx_full <= 1'b1;
            end else if (rx_ack) begin
                rx_full <= 1'b0;
            end

            if (rx_done && rx_full && !rx_ack) ovrn <= 1'b1;
            else if (wr_ctrl && bus_wdata[OVRN_BIT]) ovrn <= 1'b0;

            if (wr_ctrl) begin
                ctrl.mode   <= bus_wdata[MODE_LSB +: 2];
                ctrl.tx_ovr <= bus_wdata[TXOVR_BIT];
                ctrl.rx_ovr <= bus_wdata[RXOVR_BIT];
            end
            if (wr_rate) begin
                rate.step  <= bus_wdata[STEP_W-1:0];
                rate.scale <= bus_wdata[SCALE_LSB +: SCALE_W];
            end
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_DATA: bus_rdata = pack_data(tx_ready, rx_full, rx_hold);
            OFS_CTRL: bus_rdata = pack_ctrl(ctrl, ovrn);
            OFS_RATE: bus_rdata = pack_rate(rate);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ser_port_core.sv
module ser_port_core
    import ser_pkg::*;
#(
    parameter int unsigned OVS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic                bit_tick,
    input  logic                rxd,
    output logic                txd,
    input  logic                cts_n,
    output logic                rts_n,
    output logic [1:0]          if_mode,
    output logic [STEP_W-1:0]   rate_step,
    output logic [SCALE_W-1:0]  rate_scale
);
    logic                 tx_rdy, tx_go, cts_ok;
    logic [DATA_BITS-1:0] tx_dat, rx_dat, rx_hold;
    logic                 rx_fin, rx_full, ovr_flag;
    ctrl_t                ctrl;
    rate_t                rate;

    assign cts_ok     = ctrl.tx_ovr || !cts_n;
    assign rts_n      = !(ctrl.rx_ovr || !rx_full);
    assign if_mode    = ctrl.mode;
    assign rate_step  = rate.step;
    assign rate_scale = rate.scale;

    ser_regs u_regs (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_ready(tx_rdy), .tx_load(tx_go), .tx_byte(tx_dat),
        .rx_done(rx_fin), .rx_byte(rx_dat), .rx_hold(rx_hold),
        .rx_full(rx_full), .ovrn(ovr_flag), .ctrl(ctrl), .rate(rate)
    );

    ser_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst(rst), .tick(bit_tick), .load(tx_go), .din(tx_dat),
        .cts_ok(cts_ok), .ready(tx_rdy), .txd(txd)
    );

    ser_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst(rst), .tick(bit_tick), .rxd(rxd),
        .done(rx_fin), .dout(rx_dat)
    );
endmodule

// File: rtl/ser_port_chk.sv
module ser_port_chk
    import ser_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_valid,
    input logic                 bus_write,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [WORD_W-1:0]    bus_wdata,
    input logic                 txd,
    input logic                 tx_rdy,
    input logic                 tx_go,
    input logic                 rx_fin,
    input logic                 rx_full,
    input logic [DATA_BITS-1:0] rx_hold,
    input logic                 ovr_flag
);
    logic ack_w, ovclr_w;
    assign ack_w   = bus_valid && bus_write && bus_addr == OFS_DATA && bus_wdata[RXV_BIT];
    assign ovclr_w = bus_valid && bus_write && bus_addr == OFS_CTRL && bus_wdata[OVRN_BIT];

    a_r3_idle_line_high: assert property (@(posedge clk) disable iff (rst)
        tx_rdy |-> txd);

    a_r3_ready_drops: assert property (@(posedge clk) disable iff (rst)
        tx_go |=> !tx_rdy);

    a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack_w && !rx_fin) |=> !rx_full);

    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovr_flag && !ovclr_w) |=> ovr_flag);

    a_r9_drop_keeps_hold: assert property (@(posedge clk) disable iff (rst)
        (rx_full && rx_fin && !ack_w) |=> ($stable(rx_hold) && ovr_flag && rx_full));
endmodule

bind ser_port_core ser_port_chk u_chk (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .txd(txd), .tx_rdy(tx_rdy),
    .tx_go(tx_go), .rx_fin(rx_fin), .rx_full(rx_full), .rx_hold(rx_hold),
    .ovr_flag(ovr_flag)
);

// File: tb/ser_port_core_tb_top.sv
`timescale 1ns/1ps
module ser_port_core_tb_top;
    localparam int OVS = 4;
    localparam int DIV = 4;
    localparam int BITCLK = OVS * DIV;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        bit_tick = 1'b0, rxd = 1'b1, txd, cts_n = 1'b1, rts_n;
    logic [1:0]  if_mode;
    logic [15:0] rate_step;
    logic [11:0] rate_scale;

    int n_cmp = 0, n_bad = 0;
    byte unsigned tx_q[$];

    ser_port_core #(.OVS(OVS)) dut_i (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bit_tick(bit_tick), .rxd(rxd), .txd(txd), .cts_n(cts_n), .rts_n(rts_n),
        .if_mode(if_mode), .rate_step(rate_step), .rate_scale(rate_scale)
    );

    initial forever #4 clk = ~clk;

    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            bit_tick = (c == DIV - 1);
            c = (c == DIV - 1) ? 0 : c + 1;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic bus_wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    // driver: queue the expected frame, then write byte with go bit (bit 9)
    task automatic send_byte(byte unsigned b);
        tx_q.push_back(b);
        bus_wr(4'h0, 32'h200 | 32'(b));
    endtask

    task automatic wait_tx_idle();
        logic [31:0] d;
        d = '0;
        for (int i = 0; i < 400; i++) begin
            bus_rd(4'h0, d);
            if (d[9]) break;
        end
    endtask

    task automatic drive_frame(byte unsigned b, logic stopb);
        @(negedge clk);
        rxd = 1'b0;
        repeat (BITCLK) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (BITCLK) @(negedge clk);
        end
        rxd = stopb;
        repeat (BITCLK) @(negedge clk);
        rxd = 1'b1;
        repeat (BITCLK) @(negedge clk);
    endtask

    // monitor: decode frames on txd, compare against the queue (R3)
    initial begin
        logic [7:0] got;
        wait (!rst);
        forever begin
            @(negedge txd);
            repeat (BITCLK / 2) @(negedge clk);
            chk("R3 start bit", 32'(txd), 32'd0);
            for (int i = 0; i < 8; i++) begin
                repeat (BITCLK) @(negedge clk);
                got[i] = txd;
            end
            repeat (BITCLK) @(negedge clk);
            chk("R3 stop bit", 32'(txd), 32'd1);
            if (tx_q.size() == 0) chk("R4/R5 unexpected frame", 32'(got), 32'hFFFF);
            else chk("R3 tx byte", 32'(got), 32'(tx_q.pop_front()));
        end
    end

    initial begin
        #(200000 * 8);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_rd(4'h0, d); chk("R1 data word", d, 32'h200);
        bus_rd(4'h4, d); chk("R1 ctrl word", d, 32'h0);
        bus_rd(4'h8, d); chk("R1 rate word", d, 32'h0);
        chk("R1 txd", 32'(txd), 32'd1);
        chk("R1 rts_n", 32'(rts_n), 32'd0);

        // R2 rate word
        bus_wr(4'h8, 32'hFFFF_FFFF);
        bus_rd(4'h8, d); chk("R2 rate all ones", d, 32'h0FFF_FFFF);
        bus_wr(4'h8, 32'h0ABC_1234);
        bus_rd(4'h8, d); chk("R2 rate readback", d, 32'h0ABC_1234);
        chk("R2 step out", 32'(rate_step), 32'h1234);
        chk("R2 scale out", 32'(rate_scale), 32'hABC);
        bus_rd(4'hC, d); chk("R2 unmapped", d, 32'h0);

        // R5 control field storage
        bus_wr(4'h4, 32'hFFFF_FFFF);
        bus_rd(4'h4, d); chk("R5 ctrl mask", d, 32'h18C);
        chk("R5 mode out", 32'(if_mode), 32'd3);
        bus_wr(4'h4, 32'h84);
        bus_rd(4'h4, d); chk("R5 ctrl DTE+txovr", d, 32'h84);

        // R3 transmit with override (cts_n high ignored, R6)
        send_byte(8'hA5);
        bus_rd(4'h0, d); chk("R3 ready low after load", d & 32'h200, 32'h0);
        // R5 write while busy is dropped
        bus_wr(4'h0, 32'h23C);
        wait_tx_idle();
        send_byte(8'h01); wait_tx_idle();
        send_byte(8'h80); wait_tx_idle();
        repeat (4) @(negedge clk);

        // R4 write without go bit
        bus_wr(4'h0, 32'h055);
        repeat (3 * BITCLK) @(negedge clk);
        chk("R4 txd idle", 32'(txd), 32'd1);
        bus_rd(4'h0, d); chk("R4 ready stays", d & 32'h200, 32'h200);

        // R6 flow control: DCE, no overrides
        bus_wr(4'h4, 32'h08);
        send_byte(8'h5A);
        repeat (4 * BITCLK) @(negedge clk);
        chk("R6 held txd", 32'(txd), 32'd1);
        bus_rd(4'h0, d); chk("R6 held not ready", d & 32'h200, 32'h0);
        cts_n = 1'b0;
        wait_tx_idle();
        repeat (4) @(negedge clk);
        chk("R6 queue drained", 32'(tx_q.size()), 32'd0);

        // R7 receive
        drive_frame(8'h3C, 1'b1);
        bus_rd(4'h0, d); chk("R7 rx word", d, 32'h33C);
        chk("R7 rts_n busy", 32'(rts_n), 32'd1);

        // R9 overrun
        drive_frame(8'hC3, 1'b1);
        bus_rd(4'h0, d); chk("R9 held byte kept", d, 32'h33C);
        bus_rd(4'h4, d); chk("R9 overrun set", d, 32'h208);
        bus_wr(4'h4, 32'h208);
        bus_rd(4'h4, d); chk("R9 overrun cleared", d, 32'h008);

        // R8 acknowledge
        bus_wr(4'h0, 32'h100);
        bus_rd(4'h0, d); chk("R8 valid cleared", d & 32'h300, 32'h200);
        chk("R8 rts_n ready", 32'(rts_n), 32'd0);

        // R11 framing error then recovery
        drive_frame(8'h77, 1'b0);
        bus_rd(4'h0, d); chk("R11 bad stop dropped", d & 32'h100, 32'h0);
        drive_frame(8'h77, 1'b1);
        bus_rd(4'h0, d); chk("R11 recovery", d, 32'h377);
        bus_wr(4'h0, 32'h100);

        // R10 receive override
        bus_wr(4'h4, 32'h108);
        drive_frame(8'h12, 1'b1);
        bus_rd(4'h0, d); chk("R10 rx word", d, 32'h312);
        chk("R10 rts_n forced ready", 32'(rts_n), 32'd0);

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule